// File: doc/BRIEF.md
# Dual-Issue In-Order Scheduler

This block decides, cycle by cycle, which decoded instructions a small superscalar core sends to its three execution units: a floating-point unit, an integer adder and an integer multiplier. A decode queue offers up to two instructions per cycle, oldest first. Each carries a unit code, a destination register number and two source register numbers. The scheduler holds the offered pair and issues each instruction only when nothing blocks it. An instruction is blocked if its unit is busy, if an older instruction in the same cycle takes the same unit, if one of its sources is still being produced, if it could finish ahead of an older instruction, or if the completion queue is out of space. Results retire strictly in program order, up to two per cycle.

No data is computed here. The outputs are per-cycle issue strobes, one per unit, and writeback strobes with the destination numbers. A bench can therefore count the cycles that a given instruction sequence takes and compare different orderings of the same work.

Top module: `sched_dual_issue`

## Requirements
- R1: A new pair is accepted (`in_rdy_o` high with `in_vld_i[0]` high) only in a cycle where nothing is held or every held instruction issues. If the older held instruction issues and the younger one does not, the younger one stays held alone and the input is not ready.
- R2: Instructions issue in program order, at most two per cycle. `iss_o` bit k strobes for unit code k: 0 is floating point, 1 is integer add, 2 is integer multiply. An instruction taken at a clock edge can issue in the next cycle at the earliest.
- R3: When both held instructions need the same unit, only the older one issues in that cycle.
- R4: A unit with latency L that issues in cycle t accepts its next instruction no earlier than cycle t+L. The defaults are 2 for floating point and 1 for each integer unit.
- R5: An instruction does not issue while either of its sources equals the destination of an issued instruction that has not yet written back, or the destination of the older instruction that issues in the same cycle. It may issue in the cycle after that writeback.
- R6: An instruction does not issue in a cycle where it would finish executing before an older instruction finishes. An integer operation paired behind a floating-point one therefore issues one cycle later.
- R7: Write-backs follow program order, at most two per cycle, with `wb_vld_o[1]` only together with `wb_vld_o[0]`. Slot 0 of `wb_dst_o` (bits REG_W-1:0) is the older result. An instruction with latency L that issues in cycle t writes back no earlier than cycle t+L+1.
- R8: At most CQ_DEPTH (default 4) instructions are between issue and writeback. Issue stalls when the completion queue lacks room for them.
- R9: A synchronous active-high reset drops all held and in-flight instructions. In the cycle after reset, no issue or writeback strobe is high and the input is ready.
- R10: An offered pair with `in_vld_i` equal to 2'b10 (the younger slot valid without the older slot) is ignored and causes no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 2 | Valid per offered slot; bit 0 is the older instruction |
| in_unit_i | input | 4 | Unit codes, slot 0 in bits 1:0 |
| in_dst_i | input | 2*REG_W | Destination registers, slot 0 in the low field |
| in_srca_i | input | 2*REG_W | First source registers, slot 0 in the low field |
| in_srcb_i | input | 2*REG_W | Second source registers, slot 0 in the low field |
| in_rdy_o | output | 1 | The offered pair is taken at this clock edge |
| iss_o | output | 3 | Issue strobe per unit, indexed by unit code |
| wb_vld_o | output | 2 | Writeback strobes, bit 0 the older result |
| wb_dst_o | output | 2*REG_W | Destination registers written back this cycle |

## Verification
The bench sweeps every ordered pair of unit codes, each with and without a true dependency of the younger instruction on the older one, and computes the issue and writeback cycles from the latencies. A design that let a short integer operation slip in beside a floating-point one would issue a cycle early and retire out of order. A design that ignored a pending destination would issue a dependent instruction before its operand was written. Directed sequences cover several more cases. The queue-depth case stalls every third cycle under a steady stream of paired integer operations, and a missing space check would overrun the queue. A run of floating-point operations exposes a unit counter that frees too early. Two orderings of the same six instructions show the cycle saving that a better order gives. A younger-only valid pattern and a reset in mid-flight must leave no strobe behind.

// File: rtl/sched_pkg.sv
package sched_pkg;

   localparam int UNIT_N = 3;
   localparam int UNIT_W = 2;

   localparam logic [UNIT_W-1:0] UNIT_FP  = 2'd0;
   localparam logic [UNIT_W-1:0] UNIT_ADD = 2'd1;
   localparam logic [UNIT_W-1:0] UNIT_MUL = 2'd2;

   // execute latency of a unit code
   function automatic int unit_lat(input logic [UNIT_W-1:0] code,
                                   input int lat_fp,
                                   input int lat_add,
                                   input int lat_mul);
      case (code)
         UNIT_FP:  return lat_fp;
         UNIT_MUL: return lat_mul;
         default:  return lat_add;
      endcase
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sched_unit_timer.sv
module sched_unit_timer #(
   parameter int LAT = 1,
   parameter int TW  = 1,
   parameter int IW  = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [IW-1:0] start_idx,
   output logic          free,
   output logic [TW-1:0] rem,
   output logic          fin,
   output logic [IW-1:0] fin_idx
);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("sched_unit_timer: LAT must be at least 1");
      end
      if ((1 << TW) <= LAT) begin : g_bad_tw
         $error("sched_unit_timer: TW too narrow for LAT");
      end
   endgenerate

   logic [TW-1:0] cnt_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= TW'(LAT);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         idx_q <= start_idx;
      end
   end

   assign rem     = cnt_q;
   assign fin     = (cnt_q == TW'(1));
   assign free    = (cnt_q <= TW'(1));
   assign fin_idx = idx_q;

endmodule

// File: rtl/sched_cmpl_queue.sv
module sched_cmpl_queue #(
   parameter int DEPTH = 4,
   parameter int RW    = 5,
   parameter int NU    = 3,
   parameter int IW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       alloc,
   input  logic [2*RW-1:0]  alloc_dst,
   input  logic [NU-1:0]    fin,
   input  logic [NU*IW-1:0] fin_idx,
   output logic [IW-1:0]    idx0,
   output logic [IW-1:0]    idx1,
   output logic [CW-1:0]    free_cnt,
   output logic [CW-1:0]    cnt_o,
   output logic [DEPTH-1:0] ent_vld,
   output logic [DEPTH*RW-1:0] ent_dst,
   output logic [1:0]       wb_vld,
   output logic [2*RW-1:0]  wb_dst
);

   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("sched_cmpl_queue: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] done_q;
   logic [RW-1:0]    dst_q [DEPTH];
   logic [IW-1:0]    head_q, tail_q;
   logic [CW-1:0]    cnt_q;
   logic [IW-1:0]    head1;
   logic             rt0, rt1;
   logic [CW-1:0]    n_al, n_rt;

   assign head1 = head_q + IW'(1);
   assign rt0   = vld_q[head_q] && done_q[head_q];
   assign rt1   = rt0 && vld_q[head1] && done_q[head1];
   assign n_al  = CW'(alloc[0]) + CW'(alloc[1]);
   assign n_rt  = CW'(rt0) + CW'(rt1);

   assign idx0     = tail_q;
   assign idx1     = tail_q + IW'(1);
   assign free_cnt = CW'(DEPTH) - cnt_q;
   assign cnt_o    = cnt_q;
   assign ent_vld  = vld_q;
   assign wb_vld   = {rt1, rt0};
   assign wb_dst   = {dst_q[head1], dst_q[head_q]};

   genvar e;
   generate
      for (e = 0; e < DEPTH; e++) begin : g_ent
         assign ent_dst[e*RW +: RW] = dst_q[e];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= '0;
         done_q <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if ((rt0 && head_q == IW'(i)) || (rt1 && head1 == IW'(i))) begin
               vld_q[i] <= 1'b0;
            end
            for (int u = 0; u < NU; u++) begin
               if (fin[u] && fin_idx[u*IW +: IW] == IW'(i)) begin
                  done_q[i] <= 1'b1;
               end
            end
            if ((alloc[0] && idx0 == IW'(i)) || (alloc[1] && idx1 == IW'(i))) begin
               vld_q[i]  <= 1'b1;
               done_q[i] <= 1'b0;
            end
         end
         head_q <= head_q + IW'(n_rt);
         tail_q <= tail_q + IW'(n_al);
         cnt_q  <= cnt_q + n_al - n_rt;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc[0] && idx0 == IW'(i)) begin
            dst_q[i] <= alloc_dst[0 +: RW];
         end else if (alloc[1] && idx1 == IW'(i)) begin
            dst_q[i] <= alloc_dst[RW +: RW];
         end
      end
   end

endmodule

// File: rtl/sched_issue_ctrl.sv
module sched_issue_ctrl
   import sched_pkg::*;
#(
   parameter int RW      = 5,
   parameter int DEPTH   = 4,
   parameter int CW      = 3,
   parameter int TW      = 2,
   parameter int LAT_FP  = 2,
   parameter int LAT_ADD = 1,
   parameter int LAT_MUL = 1
) (
   input  logic [1:0]          hv,
   input  logic [2*UNIT_W-1:0] hunit,
   input  logic [2*RW-1:0]     hdst,
   input  logic [2*RW-1:0]     hsa,
   input  logic [2*RW-1:0]     hsb,
   input  logic [UNIT_N-1:0]   ufree,
   input  logic [UNIT_N*TW-1:0] urem,
   input  logic [DEPTH-1:0]    ent_vld,
   input  logic [DEPTH*RW-1:0] ent_dst,
   input  logic [CW-1:0]       free_cnt,
   output logic [1:0]          go
);

   localparam int CODES = 1 << UNIT_W;

   logic [CODES-1:0]  ufp;
   logic [TW-1:0]     rmax;
   logic [UNIT_W-1:0] u0, u1;
   logic [RW-1:0]     d0, a0, b0, a1, b1;
   logic [3:0]        hit;
   int                l0, l1;
   logic              ok0, ok1;

   always_comb begin
      ufp = '0;
      ufp[UNIT_N-1:0] = ufree;
      rmax = '0;
      for (int u = 0; u < UNIT_N; u++) begin
         if (urem[u*TW +: TW] > rmax) rmax = urem[u*TW +: TW];
      end
      u0 = hunit[0 +: UNIT_W];
      u1 = hunit[UNIT_W +: UNIT_W];
      d0 = hdst[0 +: RW];
      a0 = hsa[0 +: RW];
      b0 = hsb[0 +: RW];
      a1 = hsa[RW +: RW];
      b1 = hsb[RW +: RW];
      hit = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (ent_vld[e]) begin
            if (ent_dst[e*RW +: RW] == a0) hit[0] = 1'b1;
            if (ent_dst[e*RW +: RW] == b0) hit[1] = 1'b1;
            if (ent_dst[e*RW +: RW] == a1) hit[2] = 1'b1;
            if (ent_dst[e*RW +: RW] == b1) hit[3] = 1'b1;
         end
      end
      l0 = unit_lat(u0, LAT_FP, LAT_ADD, LAT_MUL);
      l1 = unit_lat(u1, LAT_FP, LAT_ADD, LAT_MUL);
      // the newcomer must not finish before any unit still executing
      ok0 = hv[0] && ufp[u0] && !hit[0] && !hit[1]
            && (l0 + 1 >= int'(rmax)) && (free_cnt != '0);
      ok1 = ok0 && hv[1] && ufp[u1] && (u1 != u0)
            && !hit[2] && !hit[3] && (a1 != d0) && (b1 != d0)
            && (l1 >= l0) && (l1 + 1 >= int'(rmax))
            && (free_cnt >= CW'(2));
      go = {ok1, ok0};
   end

endmodule

// File: rtl/sched_dual_issue.sv
module sched_dual_issue
   import sched_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int CQ_DEPTH = 4,
   parameter int LAT_FP   = 2,
   parameter int LAT_ADD  = 1,
   parameter int LAT_MUL  = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          in_vld_i,
   input  logic [2*UNIT_W-1:0] in_unit_i,
   input  logic [2*REG_W-1:0]  in_dst_i,
   input  logic [2*REG_W-1:0]  in_srca_i,
   input  logic [2*REG_W-1:0]  in_srcb_i,
   output logic                in_rdy_o,
   output logic [UNIT_N-1:0]   iss_o,
   output logic [1:0]          wb_vld_o,
   output logic [2*REG_W-1:0]  wb_dst_o
);

   localparam int CQ_IW   = $clog2(CQ_DEPTH);
   localparam int CQ_CW   = $clog2(CQ_DEPTH + 1);
   localparam int LAT_MAX = max3(LAT_FP, LAT_ADD, LAT_MUL);
   localparam int TW      = $clog2(LAT_MAX + 1);

   generate
      if (REG_W < 1) begin : g_bad_reg
         $error("sched_dual_issue: REG_W must be positive");
      end
      if (LAT_FP < 1 || LAT_ADD < 1 || LAT_MUL < 1) begin : g_bad_lat
         $error("sched_dual_issue: every latency must be at least 1");
      end
   endgenerate

   // held pair, slot 0 older
   logic [1:0]          hv_q;
   logic [2*UNIT_W-1:0] hunit_q;
   logic [2*REG_W-1:0]  hdst_q, hsa_q, hsb_q;

   logic [1:0]            go;
   logic                  take;
   logic [UNIT_N-1:0]     ufree, ufin, ustart;
   logic [UNIT_N*TW-1:0]  urem;
   logic [UNIT_N*CQ_IW-1:0] ufin_idx;
   logic [CQ_IW-1:0]      idx0, idx1;
   logic [CQ_CW-1:0]      free_cnt, cq_cnt;
   logic [CQ_DEPTH-1:0]   ent_vld;
   logic [CQ_DEPTH*REG_W-1:0] ent_dst;

   assign in_rdy_o = !hv_q[0] || (go[0] && (!hv_q[1] || go[1]));
   assign take     = in_rdy_o && in_vld_i[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         hv_q <= '0;
      end else if (take) begin
         hv_q <= {in_vld_i[1], 1'b1};
      end else if (go[0] && hv_q[1] && !go[1]) begin
         hv_q <= 2'b01;
      end else if (go[0]) begin
         hv_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         hunit_q <= in_unit_i;
         hdst_q  <= in_dst_i;
         hsa_q   <= in_srca_i;
         hsb_q   <= in_srcb_i;
      end else if (go[0] && hv_q[1] && !go[1]) begin
         hunit_q[0 +: UNIT_W] <= hunit_q[UNIT_W +: UNIT_W];
         hdst_q[0 +: REG_W]   <= hdst_q[REG_W +: REG_W];
         hsa_q[0 +: REG_W]    <= hsa_q[REG_W +: REG_W];
         hsb_q[0 +: REG_W]    <= hsb_q[REG_W +: REG_W];
      end
   end

   sched_issue_ctrl #(
      .RW(REG_W), .DEPTH(CQ_DEPTH), .CW(CQ_CW), .TW(TW),
      .LAT_FP(LAT_FP), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)
   ) u_ctrl (
      .hv(hv_q), .hunit(hunit_q), .hdst(hdst_q), .hsa(hsa_q), .hsb(hsb_q),
      .ufree(ufree), .urem(urem), .ent_vld(ent_vld), .ent_dst(ent_dst),
      .free_cnt(free_cnt), .go(go)
   );

   genvar u;
   generate
      for (u = 0; u < UNIT_N; u++) begin : g_unit
         localparam int UL = (u == 0) ? LAT_FP : ((u == 1) ? LAT_ADD : LAT_MUL);
         logic            sel0;
         logic [CQ_IW-1:0] sidx;
         assign sel0      = go[0] && (hunit_q[0 +: UNIT_W] == UNIT_W'(u));
         assign ustart[u] = sel0 || (go[1] && (hunit_q[UNIT_W +: UNIT_W] == UNIT_W'(u)));
         assign sidx      = sel0 ? idx0 : idx1;
         sched_unit_timer #(.LAT(UL), .TW(TW), .IW(CQ_IW)) u_tmr (
            .clk(clk), .rst(rst), .start(ustart[u]), .start_idx(sidx),
            .free(ufree[u]), .rem(urem[u*TW +: TW]), .fin(ufin[u]),
            .fin_idx(ufin_idx[u*CQ_IW +: CQ_IW])
         );
      end
   endgenerate

   assign iss_o = ustart;

   sched_cmpl_queue #(.DEPTH(CQ_DEPTH), .RW(REG_W), .NU(UNIT_N)) u_cq (
      .clk(clk), .rst(rst), .alloc(go), .alloc_dst(hdst_q),
      .fin(ufin), .fin_idx(ufin_idx), .idx0(idx0), .idx1(idx1),
      .free_cnt(free_cnt), .cnt_o(cq_cnt), .ent_vld(ent_vld),
      .ent_dst(ent_dst), .wb_vld(wb_vld_o), .wb_dst(wb_dst_o)
   );

endmodule

// File: rtl/sched_dual_issue_chk.sv
module sched_dual_issue_chk #(
   parameter int CQ_DEPTH = 4,
   parameter int LAT_FP   = 2,
   parameter int CW       = $clog2(CQ_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic [2:0]    iss,
   input logic [1:0]    wb_vld,
   input logic          in_rdy,
   input logic [CW-1:0] cq_cnt
);

   logic [7:0] out_q;

   always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= out_q + 8'($countones(iss)) - 8'($countones(wb_vld));
   end

   AST_TWO_MAX: assert property (@(posedge clk) disable iff (rst)
      $countones(iss) <= 2);                                        // R2
   AST_WB_PACKED: assert property (@(posedge clk) disable iff (rst)
      wb_vld[1] |-> wb_vld[0]);                                     // R7
   AST_WB_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
      $countones(wb_vld) <= int'(out_q));                           // R7
   AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst)
      int'(out_q) <= CQ_DEPTH);                                     // R8
   AST_CQ_BOUND: assert property (@(posedge clk) disable iff (rst)
      int'(cq_cnt) <= CQ_DEPTH);                                    // R8
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (iss == 3'b000 && wb_vld == 2'b00 && in_rdy)); // R9

   generate
      if (LAT_FP >= 2) begin : g_fp_gap
         AST_FP_GAP: assert property (@(posedge clk) disable iff (rst)
            iss[0] |=> !iss[0]);                                    // R4
      end
   endgenerate

endmodule

bind sched_dual_issue sched_dual_issue_chk #(
   .CQ_DEPTH(CQ_DEPTH), .LAT_FP(LAT_FP)
) u_chk (
   .clk(clk), .rst(rst), .iss(iss_o), .wb_vld(wb_vld_o),
   .in_rdy(in_rdy_o), .cq_cnt(cq_cnt)
);

// File: tb/sched_dual_issue_test.sv
module sched_dual_issue_test;

   localparam int CLK_PERIOD = 10;
   localparam int RW  = 5;
   localparam int LFP = 2;
   localparam int MAXI = 16;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [1:0]     in_vld = '0;
   logic [3:0]     in_unit = '0;
   logic [2*RW-1:0] in_dst = '0, in_sa = '0, in_sb = '0;
   logic           in_rdy;
   logic [2:0]     iss;
   logic [1:0]     wb_vld;
   logic [2*RW-1:0] wb_dst;

   int n_chk = 0;
   int n_fail = 0;
   int wd_cnt = 0;

   int p_unit [MAXI];
   int p_dst  [MAXI];
   int p_sa   [MAXI];
   int p_sb   [MAXI];
   int iss_cyc [MAXI];
   int wb_cyc  [MAXI];
   int rdy_hist [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   sched_dual_issue uut (
      .clk(clk), .rst(rst), .in_vld_i(in_vld), .in_unit_i(in_unit),
      .in_dst_i(in_dst), .in_srca_i(in_sa), .in_srcb_i(in_sb),
      .in_rdy_o(in_rdy), .iss_o(iss), .wb_vld_o(wb_vld), .wb_dst_o(wb_dst)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 20000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd_cnt);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int lat(input int u);
      return (u == 0) ? LFP : 1;
   endfunction

   task automatic set_ins(input int i, input int u, input int d, input int a, input int b);
      p_unit[i] = u; p_dst[i] = d; p_sa[i] = a; p_sb[i] = b;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_vld = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic drive_slot(input int s, input int i);
      in_unit[s*2 +: 2] = 2'(p_unit[i]);
      in_dst[s*RW +: RW] = RW'(p_dst[i]);
      in_sa[s*RW +: RW]  = RW'(p_sa[i]);
      in_sb[s*RW +: RW]  = RW'(p_sb[i]);
   endtask

   // runs program 0..n-1; cycle 0 is the first cycle after reset
   task automatic run_prog(input int n);
      int p, nis, nwb, k;
      p = 0; nis = 0; nwb = 0;
      for (int i = 0; i < MAXI; i++) begin iss_cyc[i] = -1; wb_cyc[i] = -1; end
      do_reset();
      for (int cyc = 0; cyc < 60 && nwb < n; cyc++) begin
         if (n - p >= 2) begin
            in_vld = 2'b11; drive_slot(0, p); drive_slot(1, p + 1);
         end else if (n - p == 1) begin
            in_vld = 2'b01; drive_slot(0, p);
         end else begin
            in_vld = 2'b00;
         end
         #1;
         rdy_hist[cyc] = int'(in_rdy);
         if (cyc == 0) begin
            check("R9 ready after reset", int'(in_rdy), 1);
            check("R9 no strobe after reset", int'(iss) + int'(wb_vld), 0);
         end
         k = $countones(iss);
         for (int j = 0; j < k; j++) begin
            if (nis < n) begin
               if (!iss[p_unit[nis]]) check("R2 issued unit matches program order", int'(iss), 1 << p_unit[nis]);
               iss_cyc[nis] = cyc;
               nis++;
            end
         end
         if (wb_vld == 2'b10) check("R7 writeback slot packing", int'(wb_vld), 3);
         for (int j = 0; j < 2; j++) begin
            if (wb_vld[j] && nwb < n) begin
               if (int'(wb_dst[j*RW +: RW]) != p_dst[nwb])
                  check("R7 writeback order", int'(wb_dst[j*RW +: RW]), p_dst[nwb]);
               wb_cyc[nwb] = cyc;
               nwb++;
            end
         end
         if (in_rdy && in_vld[0]) p += in_vld[1] ? 2 : 1;
         @(negedge clk);
      end
      in_vld = '0;
      check("R7 all results written back", nwb, n);
   endtask

   initial begin
      int i1, wb0, wb1, l0, l1;
      string tag;

      // exhaustive sweep of ordered unit pairs, with and without dependency
      for (int u0 = 0; u0 < 3; u0++) begin
         for (int u1 = 0; u1 < 3; u1++) begin
            for (int dep = 0; dep < 2; dep++) begin
               set_ins(0, u0, 1, 2, 3);
               set_ins(1, u1, 4, dep ? 1 : 5, 6);
               run_prog(2);
               l0 = lat(u0); l1 = lat(u1);
               wb0 = l0 + 2;
               if (u1 == u0)      begin i1 = 1 + l0;        tag = "R3 same-unit pair"; end
               else if (l1 < l0)  begin i1 = 1 + (l0 - l1); tag = "R6 shorter op behind longer"; end
               else               begin i1 = 1;             tag = "R2 dual issue"; end
               if (dep) begin
                  if (wb0 + 1 > i1) i1 = wb0 + 1;
                  tag = "R5 true dependency";
               end
               wb1 = (i1 + l1 + 1 > wb0) ? i1 + l1 + 1 : wb0;
               check("R2 older issue cycle", iss_cyc[0], 1);
               check(tag, iss_cyc[1], i1);
               check("R7 older writeback cycle", wb_cyc[0], wb0);
               check("R7 younger writeback cycle", wb_cyc[1], wb1);
            end
         end
      end

      // sequence A: original order
      set_ins(0, 0, 12, 13, 14); set_ins(1, 1, 1, 8, 9);
      set_ins(2, 2, 4, 2, 3);    set_ins(3, 2, 5, 6, 7);
      set_ins(4, 1, 10, 5, 7);   set_ins(5, 1, 11, 2, 3);
      run_prog(6);
      begin
         int ei[6] = '{1, 2, 3, 4, 7, 8};
         int ew[6] = '{4, 4, 5, 6, 9, 10};
         for (int i = 0; i < 6; i++) begin
            check("R2 sequence A issue", iss_cyc[i], ei[i]);
            check("R7 sequence A writeback", wb_cyc[i], ew[i]);
         end
      end
      check("R1 younger held alone blocks input", rdy_hist[1], 0);
      check("R1 input ready once held pair drains", rdy_hist[2], 1);

      // sequence B: same work reordered
      set_ins(0, 0, 12, 13, 14); set_ins(1, 1, 1, 8, 9);
      set_ins(2, 1, 11, 2, 3);   set_ins(3, 2, 5, 6, 7);
      set_ins(4, 1, 10, 5, 7);   set_ins(5, 2, 4, 2, 3);
      run_prog(6);
      begin
         int ei[6] = '{1, 2, 3, 3, 6, 6};
         int ew[6] = '{4, 4, 5, 5, 8, 8};
         for (int i = 0; i < 6; i++) begin
            check("R5 sequence B issue", iss_cyc[i], ei[i]);
            check("R7 sequence B writeback", wb_cyc[i], ew[i]);
         end
      end

      // sequence C: completion queue fills
      for (int i = 0; i < 12; i++) set_ins(i, (i % 2) + 1, i + 1, 20, 21);
      run_prog(12);
      begin
         int ei[6] = '{1, 2, 4, 5, 7, 8};
         for (int i = 0; i < 12; i++) begin
            check("R8 queue-limited issue", iss_cyc[i], ei[i/2]);
            check("R7 queue-limited writeback", wb_cyc[i], ei[i/2] + 2);
         end
      end

      // sequence D: floating-point unit occupancy
      for (int i = 0; i < 4; i++) set_ins(i, 0, i + 1, 20, 21);
      run_prog(4);
      for (int i = 0; i < 4; i++) begin
         check("R4 fp unit spacing", iss_cyc[i], 1 + 2*i);
         check("R7 fp writeback", wb_cyc[i], 4 + 2*i);
      end

      // younger-only valid is ignored
      do_reset();
      in_vld = 2'b10; in_unit = 4'b0000; in_dst = '0; in_sa = '0; in_sb = '0;
      for (int c = 0; c < 4; c++) begin
         #1;
         check("R10 younger-only slot causes no issue", int'(iss), 0);
         check("R10 input stays ready", int'(in_rdy), 1);
         @(negedge clk);
      end
      in_vld = 2'b01; in_unit = 4'b0001; in_dst = 10'd7; in_sa = 10'd8; in_sb = 10'd9;
      @(negedge clk);
      in_vld = '0;
      #1;
      check("R10 single older slot then issues", int'(iss), 2);
      @(negedge clk);

      // reset while results are in flight
      do_reset();
      in_vld = 2'b11; in_unit = 4'b1001;
      in_dst = {5'd3, 5'd2}; in_sa = {5'd20, 5'd20}; in_sb = {5'd21, 5'd21};
      @(negedge clk);
      in_vld = '0;
      #1;
      check("R9 pair issues before reset", int'(iss), 6);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R9 ready after mid-run reset", int'(in_rdy), 1);
      for (int c = 0; c < 4; c++) begin
         check("R9 flushed results never write back", int'(wb_vld), 0);
         check("R9 no issue after flush", int'(iss), 0);
         @(negedge clk);
         #1;
      end

      summary();
      $finish;
   end

endmodule